// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block is a direct-mapped branch target buffer for an instruction fetch stage. Each cycle the fetch stage presents a program counter. In the same cycle the block returns three things: whether a stored entry matches, a taken/not-taken guess read from a 2-bit saturating counter, and the target address that was stored for that branch. With the stored target, fetch can redirect at once and does not have to wait for the target to be computed.

The table changes only through a training port, which the commit stage drives for each retired branch or jump. That port carries the branch address, the resolved direction and the resolved target. A lookup never changes the table. The table holds 2^IDX_W entries. Because instructions are halfword aligned, the entry is chosen by PC[IDX_W:1]. Each entry keeps the high bits PC[31:6] as its tag, together with a valid bit, a 32-bit target and a counter.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset clears every valid bit. From the first cycle after reset, every lookup misses (`lk_hit` = 0).
- R2: A lookup hits only when the entry at index PC[7:1] is valid and its stored tag equals PC[31:6]. A PC that shares the index but has a different tag misses.
- R3: On a miss, `lk_taken` is 0 (predict not-taken).
- R4: Counter encoding: 00 is strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. On a hit, `lk_taken` equals counter bit 1.
- R5: A committed taken branch that misses allocates its entry. The entry gets valid set, the new tag, the resolved target, and counter 10 (weak taken).
- R6: A committed not-taken branch that misses does not allocate, so a later lookup of that PC still misses.
- R7: On a hit, a taken outcome increments the counter and a not-taken outcome decrements it. The counter saturates at 11 and at 00, so one opposite outcome from a strong state does not change the prediction.
- R8: On a hit, the stored target is replaced by the resolved target only when the branch was taken. A not-taken outcome leaves the target unchanged.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update. The update is visible from the next cycle.
- R10: With `upd_en` low the table does not change, whatever the other update inputs carry. Lookups never change the table.
- R11: A taken miss whose index is already held by another tag replaces that entry. After that, the previous branch misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_taken | output | 1 | Predicted direction (0 on miss) |
| lk_target | output | 32 | Stored target; meaningful only on hit |
| upd_en | input | 1 | Committed branch training strobe |
| upd_pc | input | 32 | PC of the committed branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |

## Verification
The hardest situation to reach from the ports is a lookup and an update that hit the same entry in the same cycle. The stimulus sets both buses at one falling edge, checks before the rising edge that the old contents come back, and checks again one cycle later for the new contents. The counter's hysteresis is also awkward to reach: training must first walk an entry into each saturated state and then apply one opposite outcome. The stimulus drives a fixed sequence of outcomes on a single branch and checks the prediction after every step. Index aliasing is reached with addresses that differ only in tag bits above the index.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7,
  parameter int TAG_W = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_LO = PC_W - TAG_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];

  wire [IDX_W-1:0] l_idx = lk_pc[IDX_W:1];
  wire [TAG_W-1:0] l_tag = lk_pc[PC_W-1:TAG_LO];
  wire [IDX_W-1:0] u_idx = upd_pc[IDX_W:1];
  wire [TAG_W-1:0] u_tag = upd_pc[PC_W-1:TAG_LO];

  assign lk_hit    = valid_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign lk_taken  = lk_hit && ctr_q[l_idx][1];
  assign lk_target = tgt_q[l_idx];

  wire       u_hit = valid_q[u_idx] && (tag_q[u_idx] == u_tag);
  wire [1:0] u_ctr = ctr_q[u_idx];
  logic [1:0] ctr_nx;

  always_comb begin
    if (upd_taken) ctr_nx = (u_ctr == 2'b11) ? 2'b11 : u_ctr + 2'b01;
    else           ctr_nx = (u_ctr == 2'b00) ? 2'b00 : u_ctr - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (upd_en && !u_hit && upd_taken)
      valid_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && upd_en) begin
      if (u_hit) begin
        ctr_q[u_idx] <= ctr_nx;
        if (upd_taken) tgt_q[u_idx] <= upd_target;
      end else if (upd_taken) begin
        tag_q[u_idx] <= u_tag;
        tgt_q[u_idx] <= upd_target;
        ctr_q[u_idx] <= 2'b10;
      end
    end
  end
endmodule

module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);
  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  assert_miss_not_taken_R3: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken);

  assert_taken_writes_target_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_taken) |=>
      ((lk_pc != $past(upd_pc)) || (lk_hit && lk_target == $past(upd_target))));

  assert_no_alloc_on_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && lk_pc == upd_pc && !lk_hit) |=>
      ((lk_pc != $past(lk_pc)) || !lk_hit));

  assert_keep_target_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && lk_pc == upd_pc && lk_hit) |=>
      ((lk_pc != $past(lk_pc)) || (lk_hit && lk_target == $past(lk_target))));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=>
      ((lk_pc != $past(lk_pc)) ||
       ($stable(lk_hit) && $stable(lk_taken) && (!lk_hit || $stable(lk_target)))));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .lk_target(lk_target), .upd_en(upd_en), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target)
);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PC_A = 32'h0000_1004;
  localparam logic [31:0] PC_C = 32'h0010_1004;

  always #10 clk = ~clk;

  btb_predictor dut_i (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic look(input logic [31:0] pc, input logic e_hit, input logic e_tk,
                      input logic [31:0] e_tgt, input string req);
    lk_pc = pc;
    #1;
    checks++;
    if (lk_hit !== e_hit || lk_taken !== e_tk || (e_hit && lk_target !== e_tgt)) begin
      errors++;
      $display("FAIL %s pc=%h hit/taken/target actual %b/%b/%h expected %b/%b/%h",
               req, pc, lk_hit, lk_taken, lk_target, e_hit, e_tk, e_tgt);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic t_reset_r1;
    look(PC_A, 1'b0, 1'b0, '0, "R1");
    look(32'hFFFF_FFFE, 1'b0, 1'b0, '0, "R3");
  endtask

  task automatic t_alloc_r5;
    train(PC_A, 1'b1, 32'h0000_2000);
    look(PC_A, 1'b1, 1'b1, 32'h0000_2000, "R5");
  endtask

  task automatic t_nt_miss_r6;
    train(32'h0000_0840, 1'b0, 32'h0000_9999);
    look(32'h0000_0840, 1'b0, 1'b0, '0, "R6");
  endtask

  task automatic t_counter_r7;
    train(PC_A, 1'b0, 32'h0);  look(PC_A, 1'b1, 1'b0, 32'h2000, "R4 weak nt");
    train(PC_A, 1'b0, 32'h0);  look(PC_A, 1'b1, 1'b0, 32'h2000, "R7 strong nt");
    train(PC_A, 1'b0, 32'h0);  look(PC_A, 1'b1, 1'b0, 32'h2000, "R7 sat low");
    train(PC_A, 1'b1, 32'h2000); look(PC_A, 1'b1, 1'b0, 32'h2000, "R7 nt hysteresis");
    train(PC_A, 1'b1, 32'h2000); look(PC_A, 1'b1, 1'b1, 32'h2000, "R4 weak t");
    train(PC_A, 1'b1, 32'h2000); look(PC_A, 1'b1, 1'b1, 32'h2000, "R7 strong t");
    train(PC_A, 1'b1, 32'h2000); look(PC_A, 1'b1, 1'b1, 32'h2000, "R7 sat high");
    train(PC_A, 1'b0, 32'h0);  look(PC_A, 1'b1, 1'b1, 32'h2000, "R7 t hysteresis");
  endtask

  task automatic t_target_r8;
    train(PC_A, 1'b1, 32'h0000_3000);
    look(PC_A, 1'b1, 1'b1, 32'h0000_3000, "R8 taken");
    train(PC_A, 1'b0, 32'h0000_4444);
    look(PC_A, 1'b1, 1'b1, 32'h0000_3000, "R8 not taken");
  endtask

  task automatic t_tag_r2;
    look(PC_A ^ 32'h1000_0000, 1'b0, 1'b0, '0, "R2 tag");
    look(PC_A + 32'd2, 1'b0, 1'b0, '0, "R2 index");
  endtask

  task automatic t_replace_r11;
    train(PC_C, 1'b1, 32'h0000_5000);
    look(PC_C, 1'b1, 1'b1, 32'h0000_5000, "R11 new");
    look(PC_A, 1'b0, 1'b0, '0, "R11 old");
  endtask

  task automatic t_same_cycle_r9;
    @(negedge clk);
    upd_en = 1'b1; upd_pc = 32'h0000_0400; upd_taken = 1'b1; upd_target = 32'h0000_7000;
    look(32'h0000_0400, 1'b0, 1'b0, '0, "R9 old");
    @(negedge clk);
    upd_en = 1'b0;
    look(32'h0000_0400, 1'b1, 1'b1, 32'h0000_7000, "R9 new");
  endtask

  task automatic t_idle_r10;
    @(negedge clk);
    upd_en = 1'b0; upd_pc = 32'h0000_0600; upd_taken = 1'b1; upd_target = 32'h0000_8000;
    repeat (3) @(negedge clk);
    look(32'h0000_0600, 1'b0, 1'b0, '0, "R10");
  endtask

  task automatic t_reset_again_r1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(PC_C, 1'b0, 1'b0, '0, "R1 rerun");
    look(32'h0000_0400, 1'b0, 1'b0, '0, "R1 rerun");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_alloc_r5();
    t_nt_miss_r6();
    t_counter_r7();
    t_target_r8();
    t_tag_r2();
    t_replace_r11();
    t_same_cycle_r9();
    t_idle_r10();
    t_reset_again_r1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule